// File: doc/BRIEF.md
# Scoreboard Function Unit Operand Tracker

This block is one single-entry function unit for a scoreboard-scheduled out-of-order core. It holds one add instruction at a time. When an issue strobe is accepted, the unit records the destination register number, both source register numbers and an optional immediate. From then on it watches the shared write-back bus. Each source operand that is still missing is taken from the bus in the cycle that its register is written. When both operands are present the unit runs a short fixed-length execution and then raises a release request. That request stays up until the surrounding scoreboard grants a retire strobe. In the retire cycle the unit drives its sum and destination register onto the shared write-back lines, and it then returns to idle.

Busy status, operand validity and the immediate hold are each kept in a set/reset flag in which set wins over reset. This rule lets a new instruction be issued in the same cycle the previous one retires. In that case the new instruction can take its operand straight from the bus value that the old instruction is driving. The shared write-back valid input is expected to be the OR of the retire strobes of all units, and this unit's own retire is one of them.

Top module: `fu_operand_tracker`

## Requirements
- R1: After reset, busy_o and rel_req_o are low, and wb_sel_o and wb_data_o are zero.
- R2: When issue_i is high while the unit is idle, busy_o is high from the next cycle, and dst_o shows the issued destination register number from the next cycle.
- R3: When issue_i is high while the unit is busy and no retire occurs in that cycle, the issue has no effect: dst_o and the later result are unchanged.
- R4: A source operand is captured only in a cycle where wb_valid_i is high and all 5 bits of wb_sel_i equal that source's register number. A cycle with a differing select, or with wb_valid_i low, leaves the operand missing.
- R5: Once a source operand has been captured, later write-backs to the same register do not change it.
- R6: A write-back that matches a source register in the same cycle as an accepted issue is captured for the new instruction.
- R7: When iss_imm_en_i is 1 at issue, the first operand is iss_imm_i. Write-backs to the first source register number are then ignored, and only the second operand is awaited.
- R8: rel_req_o is never high before both operands are present. It first goes high EXEC_LAT+2 cycles after the cycle of the write-back that completes the operands (default EXEC_LAT = 2). It then stays high until retire.
- R9: The result is the sum of the two operands modulo 2^DATA_W.
- R10: In a cycle where retire_i is high, wb_data_o carries the result and wb_sel_o carries the destination register. In every other cycle both are zero. From the cycle after retire, busy_o and rel_req_o are low, unless R11 applies.
- R11: An issue in the same cycle as retire is accepted. busy_o stays high, rel_req_o drops, and a source matching the retiring destination takes the value on the write-back inputs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue strobe |
| iss_dst_i | input | REG_W | Destination register number of the issued instruction |
| iss_src_a_i | input | REG_W | First source register number |
| iss_src_b_i | input | REG_W | Second source register number |
| iss_imm_en_i | input | 1 | 1: first operand is the immediate |
| iss_imm_i | input | DATA_W | Immediate value |
| wb_valid_i | input | 1 | Shared write-back valid (OR of all retire strobes) |
| wb_sel_i | input | REG_W | Shared write-back register select |
| wb_data_i | input | DATA_W | Shared write-back data |
| retire_i | input | 1 | Retire grant for this unit |
| busy_o | output | 1 | Unit holds an instruction |
| rel_req_o | output | 1 | Result ready, requesting release |
| dst_o | output | REG_W | Destination register number held |
| wb_sel_o | output | REG_W | This unit's contribution to the write-back select, zero unless retiring |
| wb_data_o | output | DATA_W | This unit's contribution to the write-back data, zero unless retiring |

## Verification
The assertions assume that retire_i is raised only while rel_req_o is high, which means the external arbiter grants retire only to a unit whose result is ready. The bench keeps to this by raising retire only after it has seen the release request. During a retire cycle the bench also drives the write-back inputs with the values this unit puts out, so that the bus stays consistent with the unit's own retire. The check on accepted issues assumes that the select inputs are stable in the issue cycle, and the bench changes them only between cycles.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int FU_DATA_W_DEF   = 32;
  localparam int FU_REG_W_DEF    = 5;
  localparam int FU_EXEC_LAT_DEF = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2,
    PH_DONE = 2'd3
  } fu_phase_e;
endpackage

// File: rtl/fu_sr_flag.sv
module fu_sr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R11
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !q_o); // R10
endmodule

// File: rtl/fu_operand_slot.sv
module fu_operand_slot #(
  parameter int DATA_W = fu_pkg::FU_DATA_W_DEF,
  parameter int REG_W  = fu_pkg::FU_REG_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fresh_i,
  input  logic              track_i,
  input  logic [REG_W-1:0]  match_sel_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clr_i,
  input  logic              wb_valid_i,
  input  logic [REG_W-1:0]  wb_sel_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cap_o
);
  function automatic logic sel_hit(input logic [REG_W-1:0] want,
                                   input logic [REG_W-1:0] seen);
    return (want ^ seen) == '0;
  endfunction

  assign cap_o = track_i && wb_valid_i && sel_hit(match_sel_i, wb_sel_i)
                 && (fresh_i || !valid_o);

  fu_sr_flag u_valid (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (cap_o),
    .clr_i (clr_i),
    .q_o   (valid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_o <= '0;
    else if (load_i) data_o <= load_data_i;
    else if (cap_o)  data_o <= wb_data_i;
  end

  AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !clr_i && !fresh_i && !load_i |=> $stable(data_o)); // R5
  AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o && !load_i |=> valid_o && data_o == $past(wb_data_i)); // R4
endmodule

// File: rtl/fu_exec_timer.sv
module fu_exec_timer #(
  parameter int DATA_W   = fu_pkg::FU_DATA_W_DEF,
  parameter int EXEC_LAT = fu_pkg::FU_EXEC_LAT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              running_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = (EXEC_LAT < 2) ? 1 : $clog2(EXEC_LAT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXEC_LAT - 1);

  function automatic logic [DATA_W-1:0] add_ops(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             finish_w;

  assign finish_w = running_o && !done_o && (cnt_q == LAST);

  fu_sr_flag u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (start_i),
    .clr_i (clr_i),
    .q_o   (running_o)
  );

  fu_sr_flag u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (finish_w),
    .clr_i (clr_i),
    .q_o   (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr_i || start_i)     cnt_q <= '0;
    else if (running_o && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_o <= '0;
    else if (start_i) result_o <= add_ops(op_a_i, op_b_i);
  end

  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clr_i |=> $stable(result_o)); // R9
  AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> running_o); // R8
endmodule

// File: rtl/fu_operand_tracker.sv
module fu_operand_tracker #(
  parameter int DATA_W   = fu_pkg::FU_DATA_W_DEF,
  parameter int REG_W    = fu_pkg::FU_REG_W_DEF,
  parameter int EXEC_LAT = fu_pkg::FU_EXEC_LAT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  input  logic [REG_W-1:0]  iss_src_a_i,
  input  logic [REG_W-1:0]  iss_src_b_i,
  input  logic              iss_imm_en_i,
  input  logic [DATA_W-1:0] iss_imm_i,
  input  logic              wb_valid_i,
  input  logic [REG_W-1:0]  wb_sel_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              retire_i,
  output logic              busy_o,
  output logic              rel_req_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [REG_W-1:0]  wb_sel_o,
  output logic [DATA_W-1:0] wb_data_o
);
  import fu_pkg::*;

  logic              busy_q, imm_q;
  logic              issue_fire, retire_fire, start_w;
  logic [REG_W-1:0]  dst_q, src_a_q, src_b_q;
  logic [REG_W-1:0]  sel_a_w, sel_b_w;
  logic              track_a_w, track_b_w;
  logic              a_valid, b_valid, a_cap, b_cap;
  logic [DATA_W-1:0] a_data, b_data, result_w;
  logic              op_a_ok, op_b_ok;
  logic              running_w, done_w;
  fu_phase_e         phase_w;

  assign retire_fire = retire_i && done_w;
  assign issue_fire  = issue_i && (!busy_q || retire_fire);

  fu_sr_flag u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (issue_fire),
    .clr_i (retire_fire),
    .q_o   (busy_q)
  );

  fu_sr_flag u_imm (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (issue_fire && iss_imm_en_i),
    .clr_i (retire_fire),
    .q_o   (imm_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
    end else if (issue_fire) begin
      dst_q   <= iss_dst_i;
      src_a_q <= iss_src_a_i;
      src_b_q <= iss_src_b_i;
    end
  end

  assign sel_a_w   = issue_fire ? iss_src_a_i : src_a_q;
  assign sel_b_w   = issue_fire ? iss_src_b_i : src_b_q;
  assign track_a_w = issue_fire ? !iss_imm_en_i : (busy_q && !imm_q);
  assign track_b_w = issue_fire || busy_q;

  fu_operand_slot #(.DATA_W(DATA_W), .REG_W(REG_W)) u_slot_a (
    .clk         (clk),
    .rst_n       (rst_n),
    .fresh_i     (issue_fire),
    .track_i     (track_a_w),
    .match_sel_i (sel_a_w),
    .load_i      (issue_fire && iss_imm_en_i),
    .load_data_i (iss_imm_i),
    .clr_i       (retire_fire),
    .wb_valid_i  (wb_valid_i),
    .wb_sel_i    (wb_sel_i),
    .wb_data_i   (wb_data_i),
    .valid_o     (a_valid),
    .data_o      (a_data),
    .cap_o       (a_cap)
  );

  fu_operand_slot #(.DATA_W(DATA_W), .REG_W(REG_W)) u_slot_b (
    .clk         (clk),
    .rst_n       (rst_n),
    .fresh_i     (issue_fire),
    .track_i     (track_b_w),
    .match_sel_i (sel_b_w),
    .load_i      (1'b0),
    .load_data_i ('0),
    .clr_i       (retire_fire),
    .wb_valid_i  (wb_valid_i),
    .wb_sel_i    (wb_sel_i),
    .wb_data_i   (wb_data_i),
    .valid_o     (b_valid),
    .data_o      (b_data),
    .cap_o       (b_cap)
  );

  assign op_a_ok = a_valid || imm_q;
  assign op_b_ok = b_valid;
  assign start_w = busy_q && op_a_ok && op_b_ok && !running_w && !done_w;

  fu_exec_timer #(.DATA_W(DATA_W), .EXEC_LAT(EXEC_LAT)) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .clr_i     (retire_fire),
    .op_a_i    (a_data),
    .op_b_i    (b_data),
    .running_o (running_w),
    .done_o    (done_w),
    .result_o  (result_w)
  );

  always_comb begin
    if (!busy_q)        phase_w = PH_IDLE;
    else if (done_w)    phase_w = PH_DONE;
    else if (running_w) phase_w = PH_EXEC;
    else                phase_w = PH_WAIT;
  end

  assign busy_o    = busy_q;
  assign rel_req_o = done_w;
  assign dst_o     = dst_q;
  assign wb_sel_o  = retire_fire ? dst_q : '0;
  assign wb_data_o = retire_fire ? result_w : '0;

  AST_ISSUE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !busy_o |=> busy_o && dst_o == $past(iss_dst_i)); // R2
  AST_ISSUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && busy_o && !retire_i |=> $stable(dst_o)); // R3
  AST_IMM_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    imm_q && !issue_fire |-> !a_cap); // R7
  AST_REL_NEEDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req_o |-> op_a_ok && op_b_ok); // R8
  AST_REL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req_o && !retire_i |=> rel_req_o); // R8
  AST_DONE_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    phase_w == PH_DONE |=> phase_w == PH_DONE || phase_w == PH_WAIT || phase_w == PH_IDLE); // R10
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i && !issue_i |=> !busy_o && !rel_req_o); // R10
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |-> wb_sel_o == '0 && wb_data_o == '0); // R10
  AST_RETIRE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> rel_req_o); // R10
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i && issue_i |=> busy_o && !rel_req_o); // R11
  AST_B_CAP_ONLY_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    b_cap |-> wb_valid_i); // R4
endmodule

// File: tb/sim_fu_operand_tracker.sv
module sim_fu_operand_tracker;
  localparam int DW  = 32;
  localparam int RW  = 5;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_i = 1'b0;
  logic [RW-1:0] iss_dst_i = '0, iss_src_a_i = '0, iss_src_b_i = '0;
  logic          iss_imm_en_i = 1'b0;
  logic [DW-1:0] iss_imm_i = '0;
  logic          wb_valid_i = 1'b0;
  logic [RW-1:0] wb_sel_i = '0;
  logic [DW-1:0] wb_data_i = '0;
  logic          retire_i = 1'b0;
  logic          busy_o, rel_req_o;
  logic [RW-1:0] dst_o, wb_sel_o;
  logic [DW-1:0] wb_data_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fu_operand_tracker #(.DATA_W(DW), .REG_W(RW), .EXEC_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .iss_dst_i(iss_dst_i),
    .iss_src_a_i(iss_src_a_i), .iss_src_b_i(iss_src_b_i),
    .iss_imm_en_i(iss_imm_en_i), .iss_imm_i(iss_imm_i),
    .wb_valid_i(wb_valid_i), .wb_sel_i(wb_sel_i), .wb_data_i(wb_data_i),
    .retire_i(retire_i), .busy_o(busy_o), .rel_req_o(rel_req_o),
    .dst_o(dst_o), .wb_sel_o(wb_sel_o), .wb_data_o(wb_data_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_issue(input logic [RW-1:0] d, input logic [RW-1:0] a,
                          input logic [RW-1:0] b, input logic imm, input logic [DW-1:0] iv);
    issue_i = 1'b1; iss_dst_i = d; iss_src_a_i = a; iss_src_b_i = b;
    iss_imm_en_i = imm; iss_imm_i = iv;
    cyc();
    issue_i = 1'b0; iss_imm_en_i = 1'b0;
  endtask

  task automatic do_wb(input logic v, input logic [RW-1:0] s, input logic [DW-1:0] d);
    wb_valid_i = v; wb_sel_i = s; wb_data_i = d;
    cyc();
    wb_valid_i = 1'b0; wb_sel_i = '0; wb_data_i = '0;
  endtask

  // called right after the completing write-back cycle
  task automatic expect_release(input string req);
    for (int k = 0; k <= LAT; k++) begin
      chk(req, {31'd0, rel_req_o}, 32'd0);
      cyc();
    end
    chk(req, {31'd0, rel_req_o}, 32'd1);
  endtask

  task automatic do_retire(input logic [RW-1:0] d, input logic [DW-1:0] r);
    retire_i = 1'b1; wb_valid_i = 1'b1; wb_sel_i = d; wb_data_i = r;
    #1;
    chk("R10 retire data", wb_data_o, r);
    chk("R10 retire sel", {27'd0, wb_sel_o}, {27'd0, d});
    cyc();
    retire_i = 1'b0; wb_valid_i = 1'b0; wb_sel_i = '0; wb_data_i = '0;
    chk("R10 busy after retire", {31'd0, busy_o}, 32'd0);
    chk("R10 rel after retire", {31'd0, rel_req_o}, 32'd0);
    chk("R10 bus quiet", wb_data_o, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 rel", {31'd0, rel_req_o}, 32'd0);
    chk("R1 wb_sel", {27'd0, wb_sel_o}, 32'd0);
    chk("R1 wb_data", wb_data_o, 32'd0);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_basic();
    do_issue(5'd3, 5'd5, 5'd6, 1'b0, '0);
    chk("R2 busy", {31'd0, busy_o}, 32'd1);
    chk("R2 dst", {27'd0, dst_o}, 32'd3);
    do_wb(1'b1, 5'd21, 32'd900);   // R4 select differs only in bit 4
    do_wb(1'b0, 5'd5, 32'd901);    // R4 valid low
    do_wb(1'b1, 5'd6, 32'd20);
    chk("R4 no early release", {31'd0, rel_req_o}, 32'd0);
    do_wb(1'b1, 5'd6, 32'd777);    // R5 second write ignored
    do_wb(1'b1, 5'd5, 32'd10);
    expect_release("R8 release timing");
    repeat (3) cyc();
    chk("R8 release held", {31'd0, rel_req_o}, 32'd1);
    do_retire(5'd3, 32'd30);       // R4 R5 R9
  endtask

  task automatic t_issue_busy();
    do_issue(5'd4, 5'd1, 5'd2, 1'b0, '0);
    do_issue(5'd7, 5'd8, 5'd9, 1'b0, '0);   // R3 ignored
    chk("R3 dst kept", {27'd0, dst_o}, 32'd4);
    do_wb(1'b1, 5'd8, 32'd500);
    do_wb(1'b1, 5'd1, 32'd40);
    do_wb(1'b1, 5'd2, 32'd2);
    expect_release("R3 release");
    do_retire(5'd4, 32'd42);
  endtask

  task automatic t_same_cycle();
    wb_valid_i = 1'b1; wb_sel_i = 5'd12; wb_data_i = 32'd100;
    do_issue(5'd11, 5'd12, 5'd13, 1'b0, '0);  // R6
    wb_valid_i = 1'b0; wb_sel_i = '0; wb_data_i = '0;
    do_wb(1'b1, 5'd13, 32'd23);
    expect_release("R6 release");
    do_retire(5'd11, 32'd123);
  endtask

  task automatic t_imm();
    do_issue(5'd14, 5'd4, 5'd15, 1'b1, 32'h0000_1000);
    do_wb(1'b1, 5'd4, 32'h5555);     // R7 ignored
    do_wb(1'b1, 5'd15, 32'd5);
    expect_release("R7 release");
    do_retire(5'd14, 32'h0000_1005);
  endtask

  task automatic t_wrap();
    do_issue(5'd2, 5'd16, 5'd17, 1'b0, '0);
    do_wb(1'b1, 5'd17, 32'd2);
    do_wb(1'b1, 5'd16, 32'hFFFF_FFFF);
    expect_release("R9 release");
    do_retire(5'd2, 32'd1);          // R9 wrap
  endtask

  task automatic t_back_to_back();
    do_issue(5'd8, 5'd18, 5'd19, 1'b0, '0);
    do_wb(1'b1, 5'd18, 32'd60);
    do_wb(1'b1, 5'd19, 32'd6);
    expect_release("R11 first release");
    issue_i = 1'b1; iss_dst_i = 5'd9; iss_src_a_i = 5'd20; iss_src_b_i = 5'd8;
    retire_i = 1'b1; wb_valid_i = 1'b1; wb_sel_i = 5'd8; wb_data_i = 32'd66;
    #1;
    chk("R11 retire data", wb_data_o, 32'd66);
    cyc();
    issue_i = 1'b0; retire_i = 1'b0; wb_valid_i = 1'b0; wb_sel_i = '0; wb_data_i = '0;
    chk("R11 busy kept", {31'd0, busy_o}, 32'd1);
    chk("R11 rel dropped", {31'd0, rel_req_o}, 32'd0);
    chk("R11 new dst", {27'd0, dst_o}, 32'd9);
    do_wb(1'b1, 5'd20, 32'd7);
    expect_release("R11 second release");
    do_retire(5'd9, 32'd73);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_issue_busy();
    t_same_cycle();
    t_imm();
    t_wrap();
    t_back_to_back();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule